// File: doc/BRIEF.md
# Dual-Set Baud Rate Generator

This block turns one fixed reference clock (3.6864 MHz by default) into per-lane timing for serial receivers and transmitters. Each lane stands for one direction of one channel. A lane produces a one-cycle sampling tick at 16 times its bit rate, a one-cycle bit tick at the bit rate, and a square-wave level for each of the two. One global set-select bit chooses between two fixed tables of standard rates. A 4-bit code per lane then picks one entry from the active table. Every lane has its own down-counting divider, and all lanes read the same pair of tables.

Software programs the block through a plain write strobe with a small address and a 4-bit data field. There is no read path and no back-pressure. A write lands on the clock edge where the strobe is sampled high. A lane reads the new settings only when its divider reaches its terminal count, so a divider is never cut short mid-period. Code 15 hands the lane over to an external bit clock, which passes through a two-stage synchronizer. Codes 13 and 14 idle the lane.

Top module: `baud_gen_dual`

## Requirements
- R1: During reset and right after it, the set select is 0 and every lane code is 0. No tick is high, every sampling level is high and every bit level is low.
- R2: With set select 0, the codes map to baud rates as follows: 0:50, 1:110, 2:134.5, 3:200, 4:300, 5:600, 6:1050, 7:1200, 8:2400, 9:4800, 10:7200, 11:9600, 12:38400.
- R3: With set select 1, the codes map to baud rates as follows: 0:75, 1:110, 2:134.5, 3:150, 4:300, 5:600, 6:1200, 7:1800, 8:2000, 9:2400, 10:4800, 11:9600, 12:19200.
- R4: In a rate mode, `tick16` is a single-cycle pulse. Its spacing is the divisor: REF_HZ / (16 x baud), rounded to the nearest integer (4608 for 50 baud, 24 for 9600 baud).
- R5: `tick1` pulses once for every 16 `tick16` pulses and only in a cycle where `tick16` is also high, so its period is 16 x divisor.
- R6: Over each sampling period of D cycles, `clk16` is high for (D+1)/2 cycles, which keeps the duty cycle within one reference cycle of 50%.
- R7: `clk1` is high for 8 of the 16 sampling periods in each bit period. In a steady rate mode it rises only in the cycle after a `tick1` pulse.
- R8: With code 15, `clk1` and `clk16` equal the lane's `ext_clk` delayed by two clock edges. `tick1` and `tick16` pulse for one cycle on each synchronized rising edge.
- R9: With code 13 or 14, all four outputs of that lane stay low.
- R10: Lanes are independent. Each lane keeps its own rate while the other lanes run other codes or modes.
- R11: A change of code or set select takes effect only at the lane's next terminal count. The period in progress completes at its old length.
- R12: A write to address 0 sets the set select from data bit 0. A write to address k (1..NLANE) sets the code of lane k-1 from data bits 3:0. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, REF_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | $clog2(NLANE+1) | Write address: 0 is set select, 1..NLANE are lane codes |
| wr_data | input | 4 | Write data |
| ext_clk | input | NLANE | External bit clock per lane, used when the lane code is 15 |
| tick16 | output | NLANE | One-cycle sampling tick per lane (16x bit rate) |
| tick1 | output | NLANE | One-cycle bit tick per lane |
| clk16 | output | NLANE | Square-wave sampling clock level per lane |
| clk1 | output | NLANE | Square-wave bit clock level per lane |

## Verification
The hardest case to reach from the ports is a configuration change that lands while a divider is partway through a long period. A change of set select is worse still, because a terminal count can fall between the set write and the code writes and load a mixed divisor for one period. The stimulus sweeps every code of both sets in turn on all lanes at once. A bench monitor counts ticks from the last write strobe. It checks that the first period after the writes keeps the old length, and it judges the new length only on the third tick after the burst, when any mixed period has passed.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  localparam int unsigned CODE_W    = 4;
  localparam int unsigned NUM_RATES = 13;
  localparam logic [CODE_W-1:0] CODE_EXT = 4'd15;

  typedef enum logic [1:0] {
    LANE_RUN = 2'd0,
    LANE_EXT = 2'd1,
    LANE_OFF = 2'd2
  } lane_mode_e;

  // Rate in tenths of a baud; 0 for codes that do not name a rate.
  function automatic int unsigned rate_tenths(input logic set_sel, input logic [CODE_W-1:0] code);
    int unsigned r;
    r = 0;
    if (!set_sel) begin
      case (code)
        4'd0:  r = 500;
        4'd1:  r = 1100;
        4'd2:  r = 1345;
        4'd3:  r = 2000;
        4'd4:  r = 3000;
        4'd5:  r = 6000;
        4'd6:  r = 10500;
        4'd7:  r = 12000;
        4'd8:  r = 24000;
        4'd9:  r = 48000;
        4'd10: r = 72000;
        4'd11: r = 96000;
        4'd12: r = 384000;
        default: r = 0;
      endcase
    end else begin
      case (code)
        4'd0:  r = 750;
        4'd1:  r = 1100;
        4'd2:  r = 1345;
        4'd3:  r = 1500;
        4'd4:  r = 3000;
        4'd5:  r = 6000;
        4'd6:  r = 12000;
        4'd7:  r = 18000;
        4'd8:  r = 20000;
        4'd9:  r = 24000;
        4'd10: r = 48000;
        4'd11: r = 96000;
        4'd12: r = 192000;
        default: r = 0;
      endcase
    end
    return r;
  endfunction

  // Nearest-integer divisor from the reference to the 16x rate.
  function automatic int unsigned rate_divisor(input int unsigned ref_hz, input logic set_sel,
                                               input logic [CODE_W-1:0] code);
    int unsigned r;
    r = rate_tenths(set_sel, code);
    if (r == 0) return 1;
    return (ref_hz * 10 + 8 * r) / (16 * r);
  endfunction

  function automatic lane_mode_e mode_of(input logic [CODE_W-1:0] code);
    if (code < CODE_W'(NUM_RATES)) return LANE_RUN;
    if (code == CODE_EXT)          return LANE_EXT;
    return LANE_OFF;
  endfunction

endpackage

// File: rtl/baud_gen_cfg.sv
module baud_gen_cfg #(
  parameter int unsigned NLANE  = 4,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned CODE_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [CODE_W-1:0]       wr_data,
  output logic                    set_sel,
  output logic [NLANE*CODE_W-1:0] codes
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_sel <= 1'b0;
      codes   <= '0;
    end else if (wr_en) begin
      if (wr_addr == '0) set_sel <= wr_data[0];
      for (int k = 0; k < int'(NLANE); k++) begin
        if (wr_addr == ADDR_W'(k + 1)) codes[k*CODE_W +: CODE_W] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/baud_gen_lane.sv
module baud_gen_lane
  import baud_gen_pkg::*;
#(
  parameter int unsigned REF_HZ = 3686400,
  parameter int unsigned DIV_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_sel,
  input  logic [CODE_W-1:0] code,
  input  logic              ext_clk,
  output logic              tick16,
  output logic              tick1,
  output logic              clk16,
  output logic              clk1
);

  localparam int unsigned RST_DIV = rate_divisor(REF_HZ, 1'b0, 4'd0);

  lane_mode_e       mode;
  logic [DIV_W-1:0] div_next;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;
  logic [3:0]       sub;
  logic [2:0]       ext_sh;
  logic             term;
  logic             ext_rise;

  always_comb begin
    mode     = mode_of(code);
    div_next = DIV_W'(rate_divisor(REF_HZ, set_sel, code));
  end

  assign term     = (cnt == '0);
  assign ext_rise = ext_sh[1] & ~ext_sh[2];

  // New settings are picked up only at the terminal count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= DIV_W'(RST_DIV - 1);
      div_q  <= DIV_W'(RST_DIV);
      sub    <= 4'hF;
      ext_sh <= '0;
    end else begin
      ext_sh <= {ext_sh[1:0], ext_clk};
      if (mode != LANE_RUN) begin
        cnt <= '0;
        sub <= 4'hF;
      end else if (term) begin
        cnt   <= div_next - 1'b1;
        div_q <= div_next;
        sub   <= sub + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    tick16 = 1'b0;
    tick1  = 1'b0;
    clk16  = 1'b0;
    clk1   = 1'b0;
    case (mode)
      LANE_RUN: begin
        tick16 = term;
        tick1  = term && (sub == 4'hF);
        clk16  = (cnt >= (div_q >> 1));
        clk1   = ~sub[3];
      end
      LANE_EXT: begin
        tick16 = ext_rise;
        tick1  = ext_rise;
        clk16  = ext_sh[1];
        clk1   = ext_sh[1];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/baud_gen_dual.sv
module baud_gen_dual
  import baud_gen_pkg::*;
#(
  parameter  int unsigned REF_HZ = 3686400,
  parameter  int unsigned NLANE  = 4,
  localparam int unsigned ADDR_W = $clog2(NLANE + 1),
  localparam int unsigned DIV_W  = $clog2(REF_HZ / 800 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [NLANE-1:0]  ext_clk,
  output logic [NLANE-1:0]  tick16,
  output logic [NLANE-1:0]  tick1,
  output logic [NLANE-1:0]  clk16,
  output logic [NLANE-1:0]  clk1
);

  logic                    set_q;
  logic [NLANE*CODE_W-1:0] code_q;

  baud_gen_cfg #(
    .NLANE (NLANE),
    .ADDR_W(ADDR_W),
    .CODE_W(CODE_W)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .set_sel(set_q),
    .codes  (code_q)
  );

  for (genvar g = 0; g < int'(NLANE); g++) begin : g_lane
    baud_gen_lane #(
      .REF_HZ(REF_HZ),
      .DIV_W (DIV_W)
    ) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_sel(set_q),
      .code   (code_q[g*CODE_W +: CODE_W]),
      .ext_clk(ext_clk[g]),
      .tick16 (tick16[g]),
      .tick1  (tick1[g]),
      .clk16  (clk16[g]),
      .clk1   (clk1[g])
    );
  end

endmodule

// File: rtl/baud_gen_dual_chk.sv
module baud_gen_dual_chk #(
  parameter int unsigned NLANE = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NLANE*4-1:0] codes,
  input logic [NLANE-1:0]   tick16,
  input logic [NLANE-1:0]   tick1,
  input logic [NLANE-1:0]   clk16,
  input logic [NLANE-1:0]   clk1
);

  assert_tick1_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick1 & ~tick16) == '0);

  for (genvar g = 0; g < int'(NLANE); g++) begin : g_chk
    logic [3:0] c;
    assign c = codes[g*4 +: 4];

    assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick16[g] |=> (!tick16[g] || c != $past(c)));

    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (c == 4'd13 || c == 4'd14) |-> (!tick16[g] && !tick1[g] && !clk16[g] && !clk1[g]));

    assert_ext_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (c == 4'd15) |-> (clk1[g] == clk16[g] && tick1[g] == tick16[g]));

    assert_clk1_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(clk1[g]) && c <= 4'd12 && $past(c) == c) |-> $past(tick1[g]));
  end

endmodule

bind baud_gen_dual baud_gen_dual_chk #(.NLANE(NLANE)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .codes (code_q),
  .tick16(tick16),
  .tick1 (tick1),
  .clk16 (clk16),
  .clk1  (clk1)
);

// File: tb/baud_gen_dual_test.sv
module baud_gen_dual_test;

  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [2:0]    wr_addr;
  logic [3:0]    wr_data;
  logic [NL-1:0] ext_clk;
  logic [NL-1:0] tick16, tick1, clk16, clk1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  real rates0 [13] = '{50.0, 110.0, 134.5, 200.0, 300.0, 600.0, 1050.0, 1200.0,
                       2400.0, 4800.0, 7200.0, 9600.0, 38400.0};
  real rates1 [13] = '{75.0, 110.0, 134.5, 150.0, 300.0, 600.0, 1200.0, 1800.0,
                       2000.0, 2400.0, 4800.0, 9600.0, 19200.0};

  int cyc [NL], hi [NL], per [NL], hiper [NL], first_per [NL], nt [NL];
  int cyc1 [NL], hi1 [NL], per1 [NL], hiper1 [NL], nt1 [NL];

  baud_gen_dual uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_clk(ext_clk), .tick16(tick16), .tick1(tick1), .clk16(clk16), .clk1(clk1)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    for (int i = 0; i < NL; i++) begin
      if (!rst_n) begin
        cyc[i] = 0; hi[i] = 0; per[i] = 0; hiper[i] = 0; first_per[i] = 0; nt[i] = 0;
        cyc1[i] = 0; hi1[i] = 0; per1[i] = 0; hiper1[i] = 0; nt1[i] = 0;
      end else begin
        if (wr_en) begin nt[i] = 0; nt1[i] = 0; end
        cyc[i]++;  if (clk16[i]) hi[i]++;
        cyc1[i]++; if (clk1[i])  hi1[i]++;
        if (tick16[i]) begin
          per[i] = cyc[i]; hiper[i] = hi[i];
          if (nt[i] == 0) first_per[i] = cyc[i];
          nt[i]++; cyc[i] = 0; hi[i] = 0;
        end
        if (tick1[i]) begin
          per1[i] = cyc1[i]; hiper1[i] = hi1[i];
          nt1[i]++; cyc1[i] = 0; hi1[i] = 0;
        end
      end
    end
  end

  function automatic int exp_div(input int s, input int c);
    real r;
    r = (s == 0) ? rates0[c] : rates1[c];
    return $rtoi(3686400.0 / (16.0 * r) + 0.5);
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  task automatic wr_end();
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_ticks(input int need, input bit use1);
    int t;
    bit ok;
    t = 0;
    do begin
      @(posedge clk);
      ok = 1;
      for (int l = 0; l < NL; l++) if ((use1 ? nt1[l] : nt[l]) < need) ok = 0;
      t++;
    end while (!ok && t < 30000);
    if (!ok) chk("R4 tick wait timeout", 0, 1);
  endtask

  function automatic string rtag(input int s);
    return (s == 0) ? "R2 set0 period" : "R3 set1 period";
  endfunction

  initial begin
    int e, prev_exp, prev_set;
    logic h1, h2, h3;
    int ex [NL];
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; ext_clk = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tick16", int'(tick16), 0);
    chk("R1 tick1", int'(tick1), 0);
    chk("R1 clk16", int'(clk16), 15);
    chk("R1 clk1", int'(clk1), 0);

    // Sweep of both rate sets on all lanes (R2 R3 R4 R6 R11)
    prev_exp = 4608; prev_set = 0;
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 13; c++) begin
        e = exp_div(s, c);
        wr(3'd0, 4'(s));
        for (int l = 0; l < NL; l++) wr(3'(l + 1), 4'(c));
        wr_end();
        wait_ticks(3, 0);
        for (int l = 0; l < NL; l++) begin
          chk(rtag(s), per[l], e);
          chk("R6 clk16 high cycles", hiper[l], (e + 1) / 2);
          if (s == prev_set) chk("R11 old period completes", first_per[l], prev_exp);
        end
        prev_exp = e; prev_set = s;
      end
    end

    // Independent lanes with bit clocks (R5 R7 R10)
    wr(3'd0, 4'd0);
    wr(3'd1, 4'd12); wr(3'd2, 4'd11); wr(3'd3, 4'd10); wr(3'd4, 4'd9);
    wr_end();
    ex[0] = 6; ex[1] = 24; ex[2] = 32; ex[3] = 48;
    wait_ticks(3, 1);
    for (int l = 0; l < NL; l++) begin
      chk("R10 lane period", per[l], ex[l]);
      chk("R5 bit period", per1[l], 16 * ex[l]);
      chk("R7 clk1 high cycles", hiper1[l], 8 * ex[l]);
    end

    // Writes to unused addresses (R12)
    wr(3'd5, 4'hF); wr(3'd6, 4'h3); wr(3'd7, 4'h1);
    wr_end();
    wait_ticks(3, 0);
    for (int l = 0; l < NL; l++) chk("R12 ignored address", per[l], ex[l]);

    // Bypass and idle codes (R8 R9 R10)
    wr(3'd2, 4'd14); wr(3'd3, 4'd15); wr(3'd4, 4'd13);
    wr_end();
    repeat (5) @(posedge clk);
    h1 = 0; h2 = 0; h3 = 0;
    for (int k = 0; k < 240; k++) begin
      @(posedge clk); #1;
      ext_clk[2] = ((k % 11) < 5);
      ext_clk[1] = ~ext_clk[1];
      ext_clk[3] = ~ext_clk[3];
      @(negedge clk);
      chk("R8 clk1 follows ext", int'(clk1[2]), int'(h2));
      chk("R8 clk16 follows ext", int'(clk16[2]), int'(h2));
      chk("R8 tick on ext rise", int'(tick16[2]), int'(h2 & ~h3));
      chk("R8 bit tick on ext rise", int'(tick1[2]), int'(h2 & ~h3));
      chk("R9 lane1 idle", int'({tick16[1], tick1[1], clk16[1], clk1[1]}), 0);
      chk("R9 lane3 idle", int'({tick16[3], tick1[3], clk16[3], clk1[3]}), 0);
      h3 = h2; h2 = h1; h1 = ext_clk[2];
    end
    chk("R10 lane0 unaffected", per[0], 6);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule